// File: doc/BRIEF.md
# Bank-Switchable Two-Port Synchronous Memory

The block is a two-port synchronous memory made of 64 independent single-port banks rather than one shared two-port array. Each port, left and right, has its own clock and its own registered controls. A port picks one bank with a 6-bit bank number and one word in that bank with a word address. A port may use any bank that the other port is not using in the same cycle. A 2-bit lane enable limits a write to the upper half or the lower half of the 18-bit word.

Each port chooses its read latency with its own mode input. In flow mode, read data appears in the cycle after the address is captured. In pipelined mode it appears one cycle later. The bidirectional data bus is split into a write-data input, a read-data output and a read-valid strobe.

When both ports select the same bank in the same cycle, both ports raise a clash flag. The left port's access completes and the right port's write is dropped, so the result is always deterministic. The word address width is a parameter. The full part uses 13 bits; simulation uses 4, and the 64-bank decode stays the same.

Top module: `bank_dp_mem`

## Requirements
- R1: Storage is 64 banks addressed by `bank_*[5:0]`, each with 2^WAW words addressed by `addr_*`. Data written to one bank/word is returned unchanged by a later read of that bank/word from either port and is not disturbed by writes to other banks.
- R2: All inputs of a port are captured on the rising edge of that port's clock. A write captured at edge k is visible to any read captured at edge k+1 or later.
- R3: A port is selected only when `cs_n_*` is 0 and `cs_*` is 1 at the capture edge. A deselected port writes nothing, returns no read data and causes no clash.
- R4: On a write (`rd_*`=0), `lane_*[1]`=1 writes bits 17:9 and `lane_*[0]`=1 writes bits 8:0. Bits of a lane that is not enabled keep their old value, and `lane_*`=2'b00 leaves the word unchanged.
- R5: With `pipe_*`=0 (flow mode), a selected read with `oe_*`=1 captured at edge k drives `rvalid_*`=1 and the word on `rdata_*` between edges k and k+1.
- R6: With `pipe_*`=1 (pipelined mode), such a read gives `rvalid_*`=0 between edges k and k+1, then `rvalid_*`=1 with the word between edges k+1 and k+2.
- R7: `rvalid_*` is 1 only as a result of a selected read captured with `oe_*`=1. When `rvalid_*` is 0, `rdata_*` is all zeros. This includes the state after reset.
- R8: If both ports are selected with equal bank numbers at the same capture edge, `clash_l` and `clash_r` are both 1 in the following cycle; otherwise both are 0.
- R9: During a clash the right port's write is discarded, while the left port's read or write completes normally.
- R10: The two ports operate concurrently on different banks in the same cycle, including writes from both ports and reads of words the other port wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| clk_r | input | 1 | Right port clock |
| rst_n | input | 1 | Asynchronous active-low reset of the port registers |
| pipe_l | input | 1 | Left read mode: 1 pipelined, 0 flow |
| cs_n_l | input | 1 | Left active-low chip select |
| cs_l | input | 1 | Left active-high chip select |
| rd_l | input | 1 | Left operation: 1 read, 0 write |
| oe_l | input | 1 | Left output enable for reads |
| lane_l | input | 2 | Left write lanes: bit 1 upper 17:9, bit 0 lower 8:0 |
| bank_l | input | 6 | Left bank number |
| addr_l | input | WAW | Left word address inside the bank |
| wdata_l | input | 18 | Left write data |
| rdata_l | output | 18 | Left read data, zero when not valid |
| rvalid_l | output | 1 | Left read data valid |
| clash_l | output | 1 | Both ports on the same bank (left view) |
| pipe_r | input | 1 | Right read mode: 1 pipelined, 0 flow |
| cs_n_r | input | 1 | Right active-low chip select |
| cs_r | input | 1 | Right active-high chip select |
| rd_r | input | 1 | Right operation: 1 read, 0 write |
| oe_r | input | 1 | Right output enable for reads |
| lane_r | input | 2 | Right write lanes: bit 1 upper 17:9, bit 0 lower 8:0 |
| bank_r | input | 6 | Right bank number |
| addr_r | input | WAW | Right word address inside the bank |
| wdata_r | input | 18 | Right write data |
| rdata_r | output | 18 | Right read data, zero when not valid |
| rvalid_r | output | 1 | Right read data valid |
| clash_r | output | 1 | Both ports on the same bank (right view) |

## Verification
Two of the block's functions can fall in one cycle: ordinary concurrent traffic by both ports and bank-clash resolution. The bench provokes both from the same cycle-by-cycle table. Most rows send the two ports to different banks at the same edge, and other rows send them to one bank. In the clash rows the flags must rise and the right port's write must be gone when the word is read back afterwards. Clash rows use both a write against a write and a left read against a right write. A separate case points a deselected port at the other port's bank, where no clash may appear.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
    localparam int DW      = 18;
    localparam int LO_W    = 9;
    localparam int HI_W    = DW - LO_W;
    localparam int BANK_AW = 6;
    localparam int NBANK   = 1 << BANK_AW;

    typedef logic [DW-1:0]      word_t;
    typedef logic [BANK_AW-1:0] bank_t;

    // expand the two lane enables into a per-bit write mask
    function automatic word_t lane_mask(input logic [1:0] lanes);
        return {{HI_W{lanes[1]}}, {LO_W{lanes[0]}}};
    endfunction
endpackage

// File: rtl/bdp_port.sv
module bdp_port
    import bdp_pkg::*;
#(
    parameter int WAW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pipe,
    input  logic           cs_n,
    input  logic           cs,
    input  logic           rd,
    input  logic           oe,
    input  logic [1:0]     lanes,
    input  bank_t          bank,
    input  logic [WAW-1:0] addr,
    input  word_t          wdata,
    input  word_t          rd_word,
    output logic           sel_q,
    output logic           wr_q,
    output bank_t          bank_q,
    output logic [WAW-1:0] addr_q,
    output word_t          wdata_q,
    output word_t          mask_q,
    output word_t          rdata,
    output logic           rvalid
);
    typedef struct packed {
        logic           sel;
        logic           rd;
        logic           oe;
        logic           pipe;
        logic [1:0]     lanes;
        bank_t          bank;
        logic [WAW-1:0] addr;
        word_t          wdata;
        logic           v2;
        word_t          d2;
    } st_t;

    st_t  st_d, st_q;
    logic flow_v;

    always_comb begin
        flow_v      = st_q.sel & st_q.rd & st_q.oe;
        st_d        = st_q;
        st_d.sel    = ~cs_n & cs;
        st_d.rd     = rd;
        st_d.oe     = oe;
        st_d.pipe   = pipe;
        st_d.lanes  = lanes;
        st_d.bank   = bank;
        st_d.addr   = addr;
        st_d.wdata  = wdata;
        st_d.v2     = flow_v & st_q.pipe;
        st_d.d2     = (flow_v & st_q.pipe) ? rd_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_q   = st_q.sel;
    assign wr_q    = st_q.sel & ~st_q.rd & (|st_q.lanes);
    assign bank_q  = st_q.bank;
    assign addr_q  = st_q.addr;
    assign wdata_q = st_q.wdata;
    assign mask_q  = lane_mask(st_q.lanes);
    assign rvalid  = (flow_v & ~st_q.pipe) | st_q.v2;
    assign rdata   = st_q.v2 ? st_q.d2 : ((flow_v & ~st_q.pipe) ? rd_word : '0);
endmodule

// File: rtl/bdp_bank.sv
module bdp_bank
    import bdp_pkg::*;
#(
    parameter int WAW = 4
) (
    input  logic           clk_l,
    input  logic           clk_r,
    input  logic           wen_l,
    input  logic           wen_r,
    input  logic [WAW-1:0] addr_l,
    input  logic [WAW-1:0] addr_r,
    input  word_t          wdata_l,
    input  word_t          wdata_r,
    input  word_t          mask_l,
    input  word_t          mask_r,
    output word_t          rword_l,
    output word_t          rword_r
);
    localparam int WORDS = 1 << WAW;

    // each half is written from one clock only; a word is the XOR of both halves
    word_t half_l [WORDS];
    word_t half_r [WORDS];

    always_ff @(posedge clk_l) begin
        if (wen_l)
            half_l[addr_l] <= (half_l[addr_l] & ~mask_l)
                            | ((wdata_l ^ half_r[addr_l]) & mask_l);
    end

    always_ff @(posedge clk_r) begin
        if (wen_r)
            half_r[addr_r] <= (half_r[addr_r] & ~mask_r)
                            | ((wdata_r ^ half_l[addr_r]) & mask_r);
    end

    assign rword_l = half_l[addr_l] ^ half_r[addr_l];
    assign rword_r = half_l[addr_r] ^ half_r[addr_r];
endmodule

// File: rtl/bank_dp_mem.sv
module bank_dp_mem
    import bdp_pkg::*;
#(
    parameter int WAW = 4
) (
    input  logic           clk_l,
    input  logic           clk_r,
    input  logic           rst_n,
    input  logic           pipe_l,
    input  logic           cs_n_l,
    input  logic           cs_l,
    input  logic           rd_l,
    input  logic           oe_l,
    input  logic [1:0]     lane_l,
    input  logic [5:0]     bank_l,
    input  logic [WAW-1:0] addr_l,
    input  logic [17:0]    wdata_l,
    output logic [17:0]    rdata_l,
    output logic           rvalid_l,
    output logic           clash_l,
    input  logic           pipe_r,
    input  logic           cs_n_r,
    input  logic           cs_r,
    input  logic           rd_r,
    input  logic           oe_r,
    input  logic [1:0]     lane_r,
    input  logic [5:0]     bank_r,
    input  logic [WAW-1:0] addr_r,
    input  logic [17:0]    wdata_r,
    output logic [17:0]    rdata_r,
    output logic           rvalid_r,
    output logic           clash_r
);
    logic           sel_lq, sel_rq, wr_lq, wr_rq, clash;
    bank_t          bank_lq, bank_rq;
    logic [WAW-1:0] addr_lq, addr_rq;
    word_t          wdata_lq, wdata_rq, mask_lq, mask_rq;
    word_t          rword_l, rword_r;
    word_t          rw_l_all [NBANK];
    word_t          rw_r_all [NBANK];

    bdp_port #(.WAW(WAW)) u_port_l (
        .clk(clk_l), .rst_n(rst_n), .pipe(pipe_l), .cs_n(cs_n_l), .cs(cs_l),
        .rd(rd_l), .oe(oe_l), .lanes(lane_l), .bank(bank_l), .addr(addr_l),
        .wdata(wdata_l), .rd_word(rword_l), .sel_q(sel_lq), .wr_q(wr_lq),
        .bank_q(bank_lq), .addr_q(addr_lq), .wdata_q(wdata_lq), .mask_q(mask_lq),
        .rdata(rdata_l), .rvalid(rvalid_l)
    );

    bdp_port #(.WAW(WAW)) u_port_r (
        .clk(clk_r), .rst_n(rst_n), .pipe(pipe_r), .cs_n(cs_n_r), .cs(cs_r),
        .rd(rd_r), .oe(oe_r), .lanes(lane_r), .bank(bank_r), .addr(addr_r),
        .wdata(wdata_r), .rd_word(rword_r), .sel_q(sel_rq), .wr_q(wr_rq),
        .bank_q(bank_rq), .addr_q(addr_rq), .wdata_q(wdata_rq), .mask_q(mask_rq),
        .rdata(rdata_r), .rvalid(rvalid_r)
    );

    // same-bank detection; the left port wins, the right write is dropped
    assign clash   = sel_lq & sel_rq & (bank_lq == bank_rq);
    assign clash_l = clash;
    assign clash_r = clash;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic wen_l_b, wen_r_b;
        assign wen_l_b = wr_lq & (bank_lq == bank_t'(b));
        assign wen_r_b = wr_rq & ~clash & (bank_rq == bank_t'(b));

        bdp_bank #(.WAW(WAW)) u_bank (
            .clk_l(clk_l), .clk_r(clk_r), .wen_l(wen_l_b), .wen_r(wen_r_b),
            .addr_l(addr_lq), .addr_r(addr_rq), .wdata_l(wdata_lq), .wdata_r(wdata_rq),
            .mask_l(mask_lq), .mask_r(mask_rq),
            .rword_l(rw_l_all[b]), .rword_r(rw_r_all[b])
        );
    end

    assign rword_l = rw_l_all[bank_lq];
    assign rword_r = rw_r_all[bank_rq];
endmodule

// File: rtl/bdp_chk.sv
module bdp_chk #(
    parameter int WAW = 4
) (
    input logic        clk_l,
    input logic        clk_r,
    input logic        rst_n,
    input logic        pipe_l,
    input logic        cs_n_l,
    input logic        cs_l,
    input logic        rd_l,
    input logic        oe_l,
    input logic [5:0]  bank_l,
    input logic [17:0] rdata_l,
    input logic        rvalid_l,
    input logic        clash_l,
    input logic        pipe_r,
    input logic        cs_n_r,
    input logic        cs_r,
    input logic        rd_r,
    input logic        oe_r,
    input logic [5:0]  bank_r,
    input logic [17:0] rdata_r,
    input logic        rvalid_r,
    input logic        clash_r
);
    logic sel_l, sel_r, rq_l, rq_r, same;
    assign sel_l = ~cs_n_l & cs_l;
    assign sel_r = ~cs_n_r & cs_r;
    assign rq_l  = sel_l & rd_l & oe_l;
    assign rq_r  = sel_r & rd_r & oe_r;
    assign same  = sel_l & sel_r & (bank_l == bank_r);

    AST_VALID_NEEDS_READ_L: assert property (@(posedge clk_l) disable iff (!rst_n)
        rvalid_l |-> ($past(rq_l) || $past(rq_l, 2)));                 // R7
    AST_ZERO_WHEN_IDLE_L: assert property (@(posedge clk_l) disable iff (!rst_n)
        !rvalid_l |-> (rdata_l == '0));                                 // R7
    AST_ZERO_WHEN_IDLE_R: assert property (@(posedge clk_r) disable iff (!rst_n)
        !rvalid_r |-> (rdata_r == '0));                                 // R7
    AST_FLOW_LATENCY_L: assert property (@(posedge clk_l) disable iff (!rst_n)
        $past(rq_l && !pipe_l) |-> rvalid_l);                           // R5
    AST_FLOW_LATENCY_R: assert property (@(posedge clk_r) disable iff (!rst_n)
        $past(rq_r && !pipe_r) |-> rvalid_r);                           // R5
    AST_PIPE_LATENCY_L: assert property (@(posedge clk_l) disable iff (!rst_n)
        $past(rq_l && pipe_l, 2) |-> rvalid_l);                         // R6
    AST_PIPE_NOT_EARLY_L: assert property (@(posedge clk_l) disable iff (!rst_n)
        ($past(rq_l && pipe_l) && !$past(rq_l, 2)) |-> !rvalid_l);      // R6
    AST_CLASH_DETECTED: assert property (@(posedge clk_l) disable iff (!rst_n)
        $past(same) |-> (clash_l && clash_r));                          // R8
    AST_CLASH_ONLY_SAME_BANK: assert property (@(posedge clk_l) disable iff (!rst_n)
        clash_l |-> $past(same));                                       // R8
    AST_NO_CLASH_DESELECTED: assert property (@(posedge clk_l) disable iff (!rst_n)
        $past(!sel_l) |-> !clash_r);                                    // R3
endmodule

bind bank_dp_mem bdp_chk #(.WAW(WAW)) u_bdp_chk (.*);

// File: tb/test_bank_dp_mem.sv
module test_bank_dp_mem;
    localparam int WAW = 4;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] ID = 2'd0, WR = 2'd1, RD = 2'd2, RX = 2'd3;

    typedef struct packed {
        logic [1:0]     lop;
        logic [5:0]     lbk;
        logic [WAW-1:0] lad;
        logic [1:0]     lln;
        logic [17:0]    ldt;
        logic [1:0]     rop;
        logic [5:0]     rbk;
        logic [WAW-1:0] rad;
        logic [1:0]     rln;
        logic [17:0]    rdt;
        logic           cex;
    } vec_t;

    localparam int NV = 12;
    // data field holds write data for WR and expected read word for RD
    localparam vec_t VECS [NV] = '{
        '{WR, 6'd3,  4'd5,  2'd3, 18'h2A5A5, WR, 6'd40, 4'd5,  2'd3, 18'h15A5A, 1'b0},
        '{WR, 6'd0,  4'd0,  2'd3, 18'h3FFFF, WR, 6'd63, 4'd15, 2'd3, 18'h00001, 1'b0},
        '{RD, 6'd40, 4'd5,  2'd0, 18'h15A5A, RD, 6'd3,  4'd5,  2'd0, 18'h2A5A5, 1'b0},
        '{RD, 6'd63, 4'd15, 2'd0, 18'h00001, RD, 6'd0,  4'd0,  2'd0, 18'h3FFFF, 1'b0},
        '{WR, 6'd3,  4'd5,  2'd2, 18'h00000, WR, 6'd40, 4'd5,  2'd1, 18'h3FFFF, 1'b0},
        '{RD, 6'd40, 4'd5,  2'd0, 18'h15BFF, RD, 6'd3,  4'd5,  2'd0, 18'h001A5, 1'b0},
        '{WR, 6'd7,  4'd2,  2'd3, 18'h12345, WR, 6'd8,  4'd2,  2'd3, 18'h0BEEF, 1'b0},
        '{WR, 6'd7,  4'd2,  2'd0, 18'h3FFFF, ID, 6'd0,  4'd0,  2'd0, 18'h00000, 1'b0},
        '{RD, 6'd8,  4'd2,  2'd0, 18'h0BEEF, RD, 6'd7,  4'd2,  2'd0, 18'h12345, 1'b0},
        '{WR, 6'd20, 4'd1,  2'd3, 18'h11111, WR, 6'd20, 4'd1,  2'd3, 18'h22222, 1'b1},
        '{RD, 6'd20, 4'd1,  2'd0, 18'h11111, ID, 6'd0,  4'd0,  2'd0, 18'h00000, 1'b0},
        '{RD, 6'd20, 4'd1,  2'd0, 18'h11111, RX, 6'd20, 4'd1,  2'd0, 18'h00000, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pipe_l = 1'b0, cs_n_l = 1'b1, cs_l = 1'b1, rd_l = 1'b1, oe_l = 1'b1;
    logic pipe_r = 1'b0, cs_n_r = 1'b1, cs_r = 1'b1, rd_r = 1'b1, oe_r = 1'b1;
    logic [1:0]     lane_l = '0, lane_r = '0;
    logic [5:0]     bank_l = '0, bank_r = '0;
    logic [WAW-1:0] addr_l = '0, addr_r = '0;
    logic [17:0]    wdata_l = '0, wdata_r = '0;
    logic [17:0]    rdata_l, rdata_r;
    logic           rvalid_l, rvalid_r, clash_l, clash_r;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_dp_mem #(.WAW(WAW)) i_bank_dp_mem (
        .clk_l(clk), .clk_r(clk), .rst_n(rst_n),
        .pipe_l(pipe_l), .cs_n_l(cs_n_l), .cs_l(cs_l), .rd_l(rd_l), .oe_l(oe_l),
        .lane_l(lane_l), .bank_l(bank_l), .addr_l(addr_l), .wdata_l(wdata_l),
        .rdata_l(rdata_l), .rvalid_l(rvalid_l), .clash_l(clash_l),
        .pipe_r(pipe_r), .cs_n_r(cs_n_r), .cs_r(cs_r), .rd_r(rd_r), .oe_r(oe_r),
        .lane_r(lane_r), .bank_r(bank_r), .addr_r(addr_r), .wdata_r(wdata_r),
        .rdata_r(rdata_r), .rvalid_r(rvalid_r), .clash_r(clash_r)
    );

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_l(input logic [1:0] op, input logic [5:0] bk, input logic [WAW-1:0] ad,
                         input logic [1:0] ln, input logic [17:0] dt);
        cs_n_l = (op == ID); cs_l = 1'b1; rd_l = op[1]; oe_l = 1'b1;
        bank_l = bk; addr_l = ad; lane_l = ln; wdata_l = dt;
    endtask

    task automatic put_r(input logic [1:0] op, input logic [5:0] bk, input logic [WAW-1:0] ad,
                         input logic [1:0] ln, input logic [17:0] dt);
        cs_n_r = (op == ID); cs_r = 1'b1; rd_r = op[1]; oe_r = 1'b1;
        bank_r = bk; addr_r = ad; lane_r = ln; wdata_r = dt;
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog expired actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state, R7 and R8
        chk("R7 reset rvalid_l", {17'd0, rvalid_l}, 18'd0);
        chk("R7 reset rdata_l", rdata_l, 18'd0);
        chk("R7 reset rvalid_r", {17'd0, rvalid_r}, 18'd0);
        chk("R8 reset clash", {16'd0, clash_l, clash_r}, 18'd0);

        // table walk in flow mode: R1 R2 R4 R5 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            put_l(VECS[i].lop, VECS[i].lbk, VECS[i].lad, VECS[i].lln, VECS[i].ldt);
            put_r(VECS[i].rop, VECS[i].rbk, VECS[i].rad, VECS[i].rln, VECS[i].rdt);
            step();
            if (VECS[i].lop[1]) begin
                chk($sformatf("R10 R4 R9 vec%0d left rdata", i), rdata_l, VECS[i].ldt);
                chk($sformatf("R5 vec%0d left rvalid", i), {17'd0, rvalid_l}, 18'd1);
            end else begin
                chk($sformatf("R7 vec%0d left no read", i), {rvalid_l, rdata_l[16:0]}, 18'd0);
            end
            if (VECS[i].rop == RD) begin
                chk($sformatf("R10 R1 R4 vec%0d right rdata", i), rdata_r, VECS[i].rdt);
                chk($sformatf("R5 vec%0d right rvalid", i), {17'd0, rvalid_r}, 18'd1);
            end else if (VECS[i].rop != RX) begin
                chk($sformatf("R7 vec%0d right no read", i), {rvalid_r, rdata_r[16:0]}, 18'd0);
            end
            chk($sformatf("R8 vec%0d clash_l", i), {17'd0, clash_l}, {17'd0, VECS[i].cex});
            chk($sformatf("R8 vec%0d clash_r", i), {17'd0, clash_r}, {17'd0, VECS[i].cex});
        end
        put_l(ID, 0, 0, 0, 0); put_r(ID, 0, 0, 0, 0);
        step();

        // R6 pipelined reads on both ports
        pipe_l = 1'b1; pipe_r = 1'b1;
        step();
        put_l(RD, 6'd3, 4'd5, 2'd0, 18'd0); put_r(RD, 6'd40, 4'd5, 2'd0, 18'd0);
        step();
        put_l(ID, 0, 0, 0, 0); put_r(ID, 0, 0, 0, 0);
        chk("R6 pipe first cycle rvalid_l", {17'd0, rvalid_l}, 18'd0);
        chk("R6 pipe first cycle rvalid_r", {17'd0, rvalid_r}, 18'd0);
        step();
        chk("R6 pipe rvalid_l", {17'd0, rvalid_l}, 18'd1);
        chk("R6 pipe rdata_l", rdata_l, 18'h001A5);
        chk("R6 pipe rdata_r", rdata_r, 18'h15BFF);
        step();
        chk("R6 pipe drops after one cycle", {17'd0, rvalid_l}, 18'd0);
        pipe_l = 1'b0; pipe_r = 1'b0;
        step();

        // R7 read with output enable low
        put_l(RD, 6'd8, 4'd2, 2'd0, 18'd0); oe_l = 1'b0;
        step();
        chk("R7 oe low rvalid_l", {17'd0, rvalid_l}, 18'd0);
        chk("R7 oe low rdata_l", rdata_l, 18'd0);

        // R3 deselected writes by each chip select
        put_l(WR, 6'd7, 4'd2, 2'd3, 18'h00000); cs_l = 1'b0;
        put_r(WR, 6'd8, 4'd2, 2'd3, 18'h00000); cs_n_r = 1'b1;
        step();
        put_l(RD, 6'd7, 4'd2, 2'd0, 18'd0); put_r(RD, 6'd8, 4'd2, 2'd0, 18'd0);
        step();
        chk("R3 deselected left write ignored", rdata_l, 18'h12345);
        chk("R3 deselected right write ignored", rdata_r, 18'h0BEEF);

        // R3 deselected port on the same bank raises no clash
        put_l(RD, 6'd20, 4'd1, 2'd0, 18'd0); cs_l = 1'b0;
        put_r(RD, 6'd20, 4'd1, 2'd0, 18'd0);
        step();
        chk("R3 no clash when left deselected", {16'd0, clash_l, clash_r}, 18'd0);
        chk("R3 deselected left gives no data", {17'd0, rvalid_l}, 18'd0);
        chk("R3 right alone reads", rdata_r, 18'h11111);

        // R9 left read against right write on one bank
        put_l(RD, 6'd20, 4'd1, 2'd0, 18'd0);
        put_r(WR, 6'd20, 4'd1, 2'd3, 18'h3AAAA);
        step();
        chk("R9 clash on read/write", {16'd0, clash_l, clash_r}, 18'd3);
        chk("R9 left read completes", rdata_l, 18'h11111);
        put_l(ID, 0, 0, 0, 0); put_r(RD, 6'd20, 4'd1, 2'd0, 18'd0);
        step();
        chk("R9 right write discarded", rdata_r, 18'h11111);
        chk("R8 clash clears", {16'd0, clash_l, clash_r}, 18'd0);
        put_r(ID, 0, 0, 0, 0);
        step();
        summary();
    end
endmodule